// File: doc/BRIEF.md
# Prefetching Texture Cache

This block is a read-only texel cache built so that a lookup that hits and a lookup that misses both come out after about one memory round trip. The tag array is updated as soon as a lookup is accepted, so it always describes what the data array will hold once every outstanding fill has landed. Each accepted lookup becomes an entry in an in-order fragment queue that holds the line index, the word within the line, a side tag supplied by the requester, and the number of fills that must be written before the entry may be served. A miss also reserves a slot in a reorder buffer and queues a line request towards memory.

Memory may answer line requests in any order. Each response carries the sequence number of its request. The reorder buffer writes the lines into the data array strictly in request order, so the data array trails the tag array by exactly the set of fills still outstanding. A controller at the head of the fragment queue waits until the required number of fills has been written, then reads the texel and presents it with its side tag on the output handshake. The queue only ever issues one line request per miss. A line that a queued fragment still points at is never reallocated: a miss that would evict it waits at the input.

The cache is direct mapped with 16 lines of 32 bytes and 32-bit texels. Up to 8 misses may be outstanding, the fragment queue holds 16 entries and the request queue holds 4.

Top module: `tcache_prefetch`

## Requirements
- R1: A lookup whose line is resident returns, on `tx_texel`, the 32-bit word selected by address bits [4:2] within the line chosen by bits [8:5] whose tag is bits [31:9].
- R2: Every accepted miss produces exactly one request on the `mreq` handshake, carrying address bits [31:5] and a 3-bit sequence number; a response returns that sequence number with a 256-bit line in which word w occupies bits [32w+31:32w]. A pending request holds its fields until taken.
- R3: Responses returned in an order different from the requests still yield the correct texel for every lookup.
- R4: Texels leave in the order their lookups were accepted, each accompanied by the side tag given with its lookup, and no texel is emitted without a matching lookup.
- R5: When the fragment queue holds 16 entries, `lk_ready` is low for any lookup.
- R6: A miss whose line slot is still referenced by a queued fragment is held off (`lk_ready` low) while lookups that hit that line are accepted; the slot is refilled only after those fragments have left, and a later lookup of the evicted line issues a new request.
- R7: With 8 misses outstanding, a further miss is held off while a hit is still accepted.
- R8: With 4 requests waiting in the request queue and `mreq_ready` low, a further miss is held off.
- R9: During and right after reset `lk_ready` is high with no lookup pending in a fresh cache, `tx_valid` is low and `mreq_valid` is low.
- R10: A lookup that hits a line whose fill is still outstanding is accepted at once, but its texel is not emitted until that fill has been written.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_texel` and `tx_side` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup accepted this cycle when high with lk_valid |
| lk_addr | input | 32 | Byte address of the texel |
| lk_side | input | 8 | Side tag carried through to the output |
| mreq_valid | output | 1 | Line request present |
| mreq_ready | input | 1 | Memory takes the request |
| mreq_laddr | output | 27 | Line address (byte address bits [31:5]) |
| mreq_seq | output | 3 | Sequence number of the request |
| mrsp_valid | input | 1 | Line response present (always taken) |
| mrsp_seq | input | 3 | Sequence number the response answers |
| mrsp_line | input | 256 | Line contents, word w at bits [32w+31:32w] |
| tx_valid | output | 1 | Texel present |
| tx_ready | input | 1 | Consumer takes the texel |
| tx_texel | output | 32 | Texel value |
| tx_side | output | 8 | Side tag of the lookup that produced the texel |

## Verification
A corrupted tag or reference count shows up as a texel whose value belongs to another address, or as an extra or missing line request, visible on the very next lookup of the affected line. A fill written out of order or a wrong head wait count shows as a texel leaving before its line arrived, which the scoreboard catches on the first texel of the fragment concerned. A broken stall condition shows within one cycle as `lk_ready` high when a queue is full, and a reference count that never returns to zero shows as a lookup that never gets accepted.

// File: rtl/tcache_pkg.sv
package tcache_pkg;

    // Configuration
    localparam int ADDR_W      = 32;
    localparam int TEXEL_W     = 32;
    localparam int LINES       = 16;
    localparam int LINE_BYTES  = 32;
    localparam int ROB_DEPTH   = 8;
    localparam int FRAG_DEPTH  = 16;
    localparam int MISSQ_DEPTH = 4;
    localparam int SIDE_W      = 8;
    localparam int CNT_W       = 8;

    // Derived
    localparam int TEXEL_BYTES = TEXEL_W / 8;
    localparam int WORDS       = LINE_BYTES / TEXEL_BYTES;
    localparam int LINE_W      = LINE_BYTES * 8;
    localparam int BSEL_W      = $clog2(TEXEL_BYTES);
    localparam int OFF_W       = $clog2(LINE_BYTES);
    localparam int WSEL_W      = $clog2(WORDS);
    localparam int IDX_W       = $clog2(LINES);
    localparam int TAG_W       = ADDR_W - IDX_W - OFF_W;
    localparam int LADDR_W     = ADDR_W - OFF_W;
    localparam int SEQ_W       = $clog2(ROB_DEPTH);
    localparam int REF_W       = $clog2(FRAG_DEPTH + 1);
    localparam int OCC_W       = $clog2(ROB_DEPTH + 1);

    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [WSEL_W-1:0]  wsel_t;
    typedef logic [SEQ_W-1:0]   seq_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [TEXEL_W-1:0] texel_t;
    typedef logic [SIDE_W-1:0]  side_t;
    typedef logic [LADDR_W-1:0] laddr_t;

    // One queued fragment: where its texel lives and how many fills it needs
    typedef struct packed {
        idx_t  idx;
        wsel_t wsel;
        side_t side;
        cnt_t  need;
    } frag_t;

    // One line request waiting to leave
    typedef struct packed {
        laddr_t laddr;
        seq_t   seq;
    } miss_t;

    // Wrap-safe "done has caught up with need"
    function automatic logic fills_reached(cnt_t done, cnt_t need);
        cnt_t diff;
        diff = done - need;
        return ~diff[CNT_W-1];
    endfunction

endpackage

// File: rtl/tc_fifo.sv
module tc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] store [DEPTH];
    logic [PW:0]  wp;
    logic [PW:0]  rp;

    assign empty = (wp == rp);
    assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
    assign dout  = store[rp[PW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) store[wp[PW-1:0]] <= din;
    end

endmodule

// File: rtl/tc_tag_stage.sv
module tc_tag_stage
    import tcache_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_valid,
    input  logic [ADDR_W-1:0]   lk_addr,
    input  logic [SIDE_W-1:0]   lk_side,
    output logic                lk_ready,
    input  logic                frag_full,
    input  logic                missq_full,
    input  logic                rob_full,
    input  seq_t                alloc_seq,
    input  logic                rel,
    input  idx_t                rel_idx,
    output logic                fire,
    output logic                miss_fire,
    output frag_t               frag_entry,
    output miss_t               miss_entry,
    output logic [LINES-1:0]    line_busy
);
    tag_t             tags   [LINES];
    logic [LINES-1:0] vld;
    logic [REF_W-1:0] refcnt [LINES];
    cnt_t             iss_cnt;

    idx_t  idx;
    tag_t  lk_tag;
    wsel_t wsel;
    logic  hit;
    logic  can_miss;
    logic  unused_bsel;

    assign idx         = lk_addr[OFF_W +: IDX_W];
    assign lk_tag      = lk_addr[ADDR_W-1 -: TAG_W];
    assign wsel        = lk_addr[BSEL_W +: WSEL_W];
    assign unused_bsel = ^lk_addr[BSEL_W-1:0];

    assign hit      = vld[idx] && (tags[idx] == lk_tag);
    assign can_miss = (refcnt[idx] == '0) && !missq_full && !rob_full;
    assign lk_ready = !frag_full && (hit || can_miss);

    assign fire      = lk_valid && lk_ready;
    assign miss_fire = fire && !hit;

    always_comb begin
        frag_entry.idx  = idx;
        frag_entry.wsel = wsel;
        frag_entry.side = lk_side;
        frag_entry.need = iss_cnt + cnt_t'(miss_fire);
        miss_entry.laddr = lk_addr[ADDR_W-1:OFF_W];
        miss_entry.seq   = alloc_seq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld     <= '0;
            iss_cnt <= '0;
            for (int i = 0; i < LINES; i++) refcnt[i] <= '0;
        end else begin
            if (miss_fire) begin
                vld[idx]  <= 1'b1;
                tags[idx] <= lk_tag;
            end
            iss_cnt <= iss_cnt + cnt_t'(miss_fire);
            for (int i = 0; i < LINES; i++) begin
                refcnt[i] <= refcnt[i]
                           + REF_W'(fire && (idx == IDX_W'(i)))
                           - REF_W'(rel && (rel_idx == IDX_W'(i)));
            end
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_busy
        assign line_busy[g] = (refcnt[g] != '0);
    end

endmodule

// File: rtl/tc_reorder_buf.sv
module tc_reorder_buf
    import tcache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  idx_t             alloc_idx,
    output seq_t             tail_seq,
    output logic             full,
    output logic [OCC_W-1:0] occ,
    input  logic             rsp_valid,
    input  seq_t             rsp_seq,
    input  line_t            rsp_line,
    output logic             fill_valid,
    output idx_t             fill_idx,
    output line_t            fill_line,
    output cnt_t             fill_cnt
);
    seq_t                 head;
    seq_t                 tail;
    logic [ROB_DEPTH-1:0] rdy;
    logic [ROB_DEPTH-1:0] rdy_n;
    idx_t                 slot_idx  [ROB_DEPTH];
    line_t                slot_line [ROB_DEPTH];

    assign tail_seq   = tail;
    assign full       = (occ == OCC_W'(ROB_DEPTH));
    assign fill_valid = rdy[head];
    assign fill_idx   = slot_idx[head];
    assign fill_line  = slot_line[head];

    always_comb begin
        rdy_n = rdy;
        if (rsp_valid)  rdy_n[rsp_seq] = 1'b1;
        if (fill_valid) rdy_n[head]    = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head     <= '0;
            tail     <= '0;
            occ      <= '0;
            rdy      <= '0;
            fill_cnt <= '0;
        end else begin
            rdy      <= rdy_n;
            tail     <= tail + SEQ_W'(alloc);
            head     <= head + SEQ_W'(fill_valid);
            occ      <= occ + OCC_W'(alloc) - OCC_W'(fill_valid);
            fill_cnt <= fill_cnt + cnt_t'(fill_valid);
        end
    end

    always_ff @(posedge clk) begin
        if (alloc)     slot_idx[tail]     <= alloc_idx;
        if (rsp_valid) slot_line[rsp_seq] <= rsp_line;
    end

endmodule

// File: rtl/tc_texel_ctrl.sv
module tc_texel_ctrl
    import tcache_pkg::*;
(
    input  logic   clk,
    input  logic   frag_empty,
    input  frag_t  head,
    input  cnt_t   fill_cnt,
    input  logic   fill_valid,
    input  idx_t   fill_idx,
    input  line_t  fill_line,
    input  logic   tx_ready,
    output logic   tx_valid,
    output texel_t tx_texel,
    output side_t  tx_side,
    output logic   pop,
    output idx_t   pop_idx
);
    line_t darr [LINES];
    line_t head_line;

    assign head_line = darr[head.idx];
    assign tx_valid  = !frag_empty && fills_reached(fill_cnt, head.need);
    assign tx_texel  = head_line[head.wsel*TEXEL_W +: TEXEL_W];
    assign tx_side   = head.side;
    assign pop       = tx_valid && tx_ready;
    assign pop_idx   = head.idx;

    always_ff @(posedge clk) begin
        if (fill_valid) darr[fill_idx] <= fill_line;
    end

endmodule

// File: rtl/tcache_prefetch.sv
module tcache_prefetch
    import tcache_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    output logic               lk_ready,
    input  logic [ADDR_W-1:0]  lk_addr,
    input  logic [SIDE_W-1:0]  lk_side,
    output logic               mreq_valid,
    input  logic               mreq_ready,
    output logic [LADDR_W-1:0] mreq_laddr,
    output logic [SEQ_W-1:0]   mreq_seq,
    input  logic               mrsp_valid,
    input  logic [SEQ_W-1:0]   mrsp_seq,
    input  logic [LINE_W-1:0]  mrsp_line,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [TEXEL_W-1:0] tx_texel,
    output logic [SIDE_W-1:0]  tx_side
);
    frag_t            frag_in;
    frag_t            frag_head;
    miss_t            miss_in;
    miss_t            miss_head;
    logic [$bits(frag_t)-1:0] frag_q;
    logic [$bits(miss_t)-1:0] miss_q;
    logic             fire;
    logic             miss_fire;
    logic             frag_empty;
    logic             frag_full;
    logic             missq_empty;
    logic             missq_full;
    logic             rob_full;
    logic [OCC_W-1:0] rob_occ;
    seq_t             alloc_seq;
    logic             pop;
    idx_t             pop_idx;
    logic             fill_valid;
    idx_t             fill_idx;
    line_t            fill_line;
    cnt_t             fill_cnt;
    logic [LINES-1:0] line_busy;

    tc_tag_stage u_tag (
        .clk        (clk),
        .rst        (rst),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .lk_side    (lk_side),
        .lk_ready   (lk_ready),
        .frag_full  (frag_full),
        .missq_full (missq_full),
        .rob_full   (rob_full),
        .alloc_seq  (alloc_seq),
        .rel        (pop),
        .rel_idx    (pop_idx),
        .fire       (fire),
        .miss_fire  (miss_fire),
        .frag_entry (frag_in),
        .miss_entry (miss_in),
        .line_busy  (line_busy)
    );

    tc_fifo #(.W($bits(frag_t)), .DEPTH(FRAG_DEPTH)) u_frag_q (
        .clk   (clk),
        .rst   (rst),
        .push  (fire),
        .din   (frag_in),
        .pop   (pop),
        .dout  (frag_q),
        .empty (frag_empty),
        .full  (frag_full)
    );
    assign frag_head = frag_t'(frag_q);

    tc_fifo #(.W($bits(miss_t)), .DEPTH(MISSQ_DEPTH)) u_miss_q (
        .clk   (clk),
        .rst   (rst),
        .push  (miss_fire),
        .din   (miss_in),
        .pop   (mreq_valid && mreq_ready),
        .dout  (miss_q),
        .empty (missq_empty),
        .full  (missq_full)
    );
    assign miss_head  = miss_t'(miss_q);
    assign mreq_valid = !missq_empty;
    assign mreq_laddr = miss_head.laddr;
    assign mreq_seq   = miss_head.seq;

    tc_reorder_buf u_rob (
        .clk        (clk),
        .rst        (rst),
        .alloc      (miss_fire),
        .alloc_idx  (frag_in.idx),
        .tail_seq   (alloc_seq),
        .full       (rob_full),
        .occ        (rob_occ),
        .rsp_valid  (mrsp_valid),
        .rsp_seq    (mrsp_seq),
        .rsp_line   (mrsp_line),
        .fill_valid (fill_valid),
        .fill_idx   (fill_idx),
        .fill_line  (fill_line),
        .fill_cnt   (fill_cnt)
    );

    tc_texel_ctrl u_ctrl (
        .clk        (clk),
        .frag_empty (frag_empty),
        .head       (frag_head),
        .fill_cnt   (fill_cnt),
        .fill_valid (fill_valid),
        .fill_idx   (fill_idx),
        .fill_line  (fill_line),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_texel   (tx_texel),
        .tx_side    (tx_side),
        .pop        (pop),
        .pop_idx    (pop_idx)
    );

endmodule

// File: rtl/tc_checker.sv
module tc_checker
    import tcache_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [TEXEL_W-1:0] tx_texel,
    input logic [SIDE_W-1:0]  tx_side,
    input logic               mreq_valid,
    input logic               mreq_ready,
    input logic [LADDR_W-1:0] mreq_laddr,
    input logic [SEQ_W-1:0]   mreq_seq,
    input logic [OCC_W-1:0]   rob_occ,
    input logic               fill_valid,
    input logic [IDX_W-1:0]   fill_idx,
    input logic [LINES-1:0]   line_busy
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!tx_valid && !mreq_valid));                                  // R9

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=>
            (tx_valid && $stable(tx_texel) && $stable(tx_side)));           // R11

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid && !mreq_ready) |=>
            (mreq_valid && $stable(mreq_laddr) && $stable(mreq_seq)));      // R2

    AST_ROB_BOUND: assert property (@(posedge clk) disable iff (rst)
        rob_occ <= OCC_W'(ROB_DEPTH));                                       // R7

    AST_FILL_REFERENCED: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> line_busy[fill_idx]);                                 // R6

endmodule

bind tcache_prefetch tc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_texel   (tx_texel),
    .tx_side    (tx_side),
    .mreq_valid (mreq_valid),
    .mreq_ready (mreq_ready),
    .mreq_laddr (mreq_laddr),
    .mreq_seq   (mreq_seq),
    .rob_occ    (rob_occ),
    .fill_valid (fill_valid),
    .fill_idx   (fill_idx),
    .line_busy  (line_busy)
);

// File: tb/sim_tcache_prefetch.sv
`timescale 1ns/1ps
module sim_tcache_prefetch;
    import tcache_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic               lk_valid;
    logic               lk_ready;
    logic [ADDR_W-1:0]  lk_addr;
    logic [SIDE_W-1:0]  lk_side;
    logic               mreq_valid;
    logic               mreq_ready;
    logic [LADDR_W-1:0] mreq_laddr;
    logic [SEQ_W-1:0]   mreq_seq;
    logic               mrsp_valid;
    logic [SEQ_W-1:0]   mrsp_seq;
    logic [LINE_W-1:0]  mrsp_line;
    logic               tx_valid;
    logic               tx_ready;
    logic [TEXEL_W-1:0] tx_texel;
    logic [SIDE_W-1:0]  tx_side;

    always #4 clk = ~clk;   // 125 MHz

    tcache_prefetch u0 (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr), .lk_side(lk_side),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_laddr(mreq_laddr), .mreq_seq(mreq_seq),
        .mrsp_valid(mrsp_valid), .mrsp_seq(mrsp_seq), .mrsp_line(mrsp_line),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_texel(tx_texel), .tx_side(tx_side)
    );

    // Stimulus table: texel byte addresses, walked in order (side tag = index)
    localparam int NV = 24;
    localparam logic [31:0] VEC [NV] = '{
        32'h0000_1000, 32'h0000_1004, 32'h0000_1024, 32'h0000_1048,
        32'h0000_1008, 32'h0000_101C, 32'h0000_2000, 32'h0000_2004,
        32'h0000_1028, 32'h0000_3064, 32'h0000_3068, 32'h0000_1000,
        32'h0000_40E0, 32'h0000_41E0, 32'h0000_41FC, 32'h0000_5120,
        32'h0000_1024, 32'h0000_2010, 32'h0000_6100, 32'h0000_6104,
        32'h0000_7180, 32'h0000_7184, 32'h0000_3060, 32'h0000_41E4
    };

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Memory contents: a fixed function of the byte address
    function automatic logic [31:0] texel_of(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[17:2]};
    endfunction

    function automatic logic [LINE_W-1:0] line_of(input logic [LADDR_W-1:0] la);
        logic [LINE_W-1:0] l;
        for (int w = 0; w < WORDS; w++)
            l[w*TEXEL_W +: TEXEL_W] = texel_of({la, WSEL_W'(w), BSEL_W'(0)});
        return l;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Scoreboard of accepted lookups
    logic [31:0] exp_tx [1024];
    logic [7:0]  exp_sd [1024];
    int exp_wr = 0;
    int exp_rd = 0;

    // Memory model: holds requests, answers newest first
    bit mem_hold = 0;
    bit mem_rdy  = 1;
    logic [LADDR_W-1:0] pend_la [16];
    logic [SEQ_W-1:0]   pend_sq [16];
    int pend_n  = 0;
    int idle    = 0;
    int req_cnt = 0;

    initial begin
        mreq_ready = 1'b0;
        mrsp_valid = 1'b0;
        mrsp_seq   = '0;
        mrsp_line  = '0;
        forever begin
            @(negedge clk);
            mrsp_valid = 1'b0;
            mreq_ready = mem_rdy;
            if (!rst && mreq_valid && mreq_ready) begin
                pend_la[pend_n] = mreq_laddr;
                pend_sq[pend_n] = mreq_seq;
                pend_n++;
                req_cnt++;
            end
            if (!rst && !mem_hold && pend_n > 0 && (pend_n >= 3 || idle >= 3)) begin
                pend_n--;
                mrsp_valid = 1'b1;
                mrsp_seq   = pend_sq[pend_n];
                mrsp_line  = line_of(pend_la[pend_n]);
                idle = 0;
            end else begin
                idle++;
            end
        end
    end

    // Output monitor
    bit tx_en = 1;
    initial begin
        tx_ready = 1'b0;
        forever begin
            @(negedge clk);
            tx_ready = tx_en;
            #1;
            if (!rst && tx_valid && tx_ready) begin
                if (exp_rd == exp_wr) begin
                    chk(0, "R4", tx_texel, 32'h0);
                end else begin
                    chk(tx_texel == exp_tx[exp_rd], "R3", tx_texel, exp_tx[exp_rd]);   // R1 R3
                    chk(tx_side == exp_sd[exp_rd], "R4", 32'(tx_side), 32'(exp_sd[exp_rd]));
                    exp_rd++;
                end
            end
        end
    end

    task automatic try_lookup(input logic [31:0] a, input logic [7:0] s, output bit ok);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        lk_side  = s;
        #1;
        ok = lk_ready;
        if (ok) begin
            exp_tx[exp_wr] = texel_of(a);
            exp_sd[exp_wr] = s;
            exp_wr++;
        end
        @(posedge clk);
        #1;
        lk_valid = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input logic [7:0] s);
        bit ok = 0;
        int tries = 0;
        while (!ok && tries < 3000) begin
            try_lookup(a, s, ok);
            tries++;
        end
        if (!ok) chk(0, "R6", 32'(tries), a);
    endtask

    // Looks at lk_ready for an address without letting the lookup be taken
    task automatic probe(input logic [31:0] a, output bit rdy);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        lk_side  = 8'hEE;
        #1;
        rdy = lk_ready;
        lk_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_rd != exp_wr && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (exp_rd != exp_wr) chk(0, "R4", 32'(exp_rd), 32'(exp_wr));
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit r;
        int rc;
        logic [31:0] t1;
        logic v1;
        rst      = 1'b1;
        lk_valid = 1'b0;
        lk_addr  = '0;
        lk_side  = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        chk(!tx_valid, "R9", 32'(tx_valid), 32'h0);
        chk(!mreq_valid, "R9", 32'(mreq_valid), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(lk_ready, "R9", 32'(lk_ready), 32'h1);
        chk(!tx_valid && !mreq_valid, "R9", 32'({tx_valid, mreq_valid}), 32'h0);

        // Table walk: hits, misses, conflicts, out-of-order fills (R1, R3, R4)
        for (int i = 0; i < NV; i++) lookup(VEC[i], 8'(i));
        drain();
        chk(exp_rd == NV, "R4", 32'(exp_rd), 32'(NV));

        // R10: hit on a line whose fill is outstanding waits for the fill
        mem_hold = 1;
        lookup(32'h0000_8A40, 8'h40);
        try_lookup(32'h0000_8A44, 8'h41, r);
        chk(r, "R10", 32'(r), 32'h1);
        repeat (20) @(negedge clk);
        #2;
        chk(!tx_valid, "R10", 32'(tx_valid), 32'h0);
        mem_hold = 0;
        drain();

        // R6: no eviction of a referenced line; hit still accepted
        mem_hold = 1;
        lookup(32'h0000_9060, 8'h50);
        probe(32'h0000_A060, r);
        chk(!r, "R6", 32'(r), 32'h0);
        probe(32'h0000_9064, r);
        chk(r, "R6", 32'(r), 32'h1);
        mem_hold = 0;
        lookup(32'h0000_A060, 8'h51);
        drain();
        rc = req_cnt;
        lookup(32'h0000_9060, 8'h52);
        drain();
        chk(req_cnt == rc + 1, "R6", 32'(req_cnt - rc), 32'h1);

        // R7: eight outstanding misses
        mem_hold = 1;
        rc = req_cnt;
        for (int k = 0; k < 8; k++) lookup(32'h0000_B000 + 32'(k * 32), 8'(8'h60 + k));
        repeat (6) @(negedge clk);
        chk(req_cnt == rc + 8, "R2", 32'(req_cnt - rc), 32'h8);
        probe(32'h0000_B100, r);
        chk(!r, "R7", 32'(r), 32'h0);
        probe(32'h0000_B004, r);
        chk(r, "R7", 32'(r), 32'h1);
        mem_hold = 0;
        drain();

        // R8: request queue full while memory refuses requests
        mem_rdy = 0;
        for (int k = 0; k < 4; k++) lookup(32'h0000_C000 + 32'(k * 32), 8'(8'h70 + k));
        probe(32'h0000_C080, r);
        chk(!r, "R8", 32'(r), 32'h0);
        chk(mreq_valid, "R8", 32'(mreq_valid), 32'h1);
        mem_rdy = 1;
        drain();

        // R5: fragment queue full; R11: output held while not taken
        tx_en = 0;
        lookup(32'h0000_D000, 8'h80);
        for (int k = 1; k < 16; k++) lookup(32'h0000_D000 + 32'((k % 8) * 4), 8'(8'h80 + k));
        repeat (30) @(negedge clk);
        probe(32'h0000_D004, r);
        chk(!r, "R5", 32'(r), 32'h0);
        @(negedge clk);
        #2;
        t1 = tx_texel;
        v1 = tx_valid;
        repeat (5) @(negedge clk);
        #2;
        chk(v1 && tx_valid && tx_texel == t1, "R11", tx_texel, t1);
        chk(t1 == texel_of(32'h0000_D000), "R1", t1, texel_of(32'h0000_D000));
        tx_en = 1;
        drain();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule